// File: doc/BRIEF.md
# AXI4-Lite Memory Exercise Master

This block is a self-contained AXI4-Lite master that tests a memory slave without a processor. Once it is released, it walks through a fixed list of transactions. Each entry has a direction, a byte address, a data word and a byte-strobe pattern. Entries come in pairs: a write to an address, then a read back from the same address. The read data is compared, lane by lane, against the bytes that the paired write enabled.

The block waits until a start input shows that the memory behind the bus is usable, for example after power-up and calibration have finished. It then runs the whole list once, with only one transaction in flight at any time. At the end it raises a done flag and holds a pass or fail verdict, together with a saturating error count. The list is computed from parameters, so the number of pairs, the base address, the address stride and the data width can change without editing a table.

Top module: `axil_traffic_gen`

## Requirements
- R1: While reset is low and after it is released, every valid output and the bready and rready outputs are low, `done`, `pass` and `fail` are 0 and `err_count` is 0.
- R2: No address or data valid is raised until `start` is sampled high at a clock edge. That first edge begins the run, and later values of `start` have no effect on it.
- R3: A run is exactly 2*NUM_PAIRS transactions (16 by default). Even-numbered entries are writes and odd-numbered entries are reads. Pair p uses byte address BASE_ADDR + p*STRIDE (stride 0x10 by default) for both its write and its read.
- R4: The write data of pair p is 0x01234567 for p=0, 0x89ABCDEF for p=1, and (p*0x11111111) XOR 0xA5A5A5A5 for p>=2, repeated across wider buses. The strobe is all ones, except when p mod 4 = 3, where only the even byte lanes are enabled (4'b0101 on a 32-bit bus).
- R5: Every transfer is a single AXI4-Lite beat with protection bits 000. A raised valid stays high, with its address, data and strobe unchanged, until the matching ready is seen.
- R6: At most one transaction is in flight. A write offers its address and data together and keeps bready high until the B handshake. A read keeps rready high until the R handshake. The next entry is issued only after that response handshake.
- R7: A write whose BRESP is not OKAY (2'b00) adds one to the error count.
- R8: A read adds one to the error count if RRESP is not OKAY, or if any byte lane enabled by the paired write differs from that write's data. Lanes the write did not enable are ignored. A read adds at most one error.
- R9: `fail` is sticky and is high exactly when the error count is nonzero. `err_count` never decreases and saturates at its maximum.
- R10: After the last response, `done` rises and stays high until reset, no further transaction is issued, and `pass` equals `done` and not `fail`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Release: the memory is ready for traffic |
| m_awaddr | output | ADDR_W | Write address |
| m_awprot | output | 3 | Write protection, always 000 |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | ADDR_W | Read address |
| m_arprot | output | 3 | Read protection, always 000 |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| done | output | 1 | Run finished, held until reset |
| pass | output | 1 | Finished with no error |
| fail | output | 1 | Sticky error flag |
| err_count | output | ERR_W | Saturating error count |

## Verification
The assertions assume a slave that obeys the AXI handshake rules. It returns a B response only after both the write address and write data handshakes, and an R response only after the read address handshake. It holds bvalid or rvalid until the matching ready is seen. Its ready signals may change in any cycle. The bench slave drives all of its outputs on the falling clock edge. It rotates its ready patterns on different periods, so address, data and read handshakes land in different cycles. It raises a response only on the falling edge after both handshakes it depends on, and injects response errors or corrupted lanes only through those legal responses.

// File: rtl/axil_tg_pkg.sv
package axil_tg_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_LAUNCH,
      SEQ_WAIT,
      SEQ_DONE
   } seq_state_e;

   localparam logic [1:0] RESP_OKAY = 2'b00;

   // 32-bit data word for pair index p
   function automatic logic [31:0] tg_word(input logic [31:0] p);
      if (p == 32'd0) return 32'h0123_4567;
      if (p == 32'd1) return 32'h89AB_CDEF;
      return (p * 32'h1111_1111) ^ 32'hA5A5_A5A5;
   endfunction

   // pairs with index 3 mod 4 write only the even byte lanes
   function automatic logic tg_partial(input logic [31:0] p);
      return p[1:0] == 2'b11;
   endfunction

endpackage

// File: rtl/axil_tg_table.sv
module axil_tg_table
   import axil_tg_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                DATA_W    = 32,
   parameter int                IDX_W     = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
   parameter int unsigned       STRIDE    = 16
) (
   input  logic [IDX_W-1:0]    idx,
   output logic                is_read,
   output logic [ADDR_W-1:0]   addr,
   output logic [DATA_W-1:0]   data,
   output logic [DATA_W/8-1:0] strb
);
   localparam int STRB_W = DATA_W / 8;
   localparam int REPL   = DATA_W / 32;

   logic [IDX_W-1:0]  pair;
   logic [31:0]       word;
   logic [STRB_W-1:0] even_lanes;

   assign pair    = idx >> 1;
   assign is_read = idx[0];
   assign word    = tg_word(32'(pair));
   assign addr    = BASE_ADDR + ADDR_W'(pair) * ADDR_W'(STRIDE);
   assign data    = {REPL{word}};

   for (genvar b = 0; b < STRB_W; b++) begin : g_lane
      assign even_lanes[b] = (b % 2 == 0);
   end

   assign strb = tg_partial(32'(pair)) ? even_lanes : '1;

endmodule

// File: rtl/axil_tg_port.sv
module axil_tg_port
   import axil_tg_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic                go_read,
   input  logic [ADDR_W-1:0]   go_addr,
   input  logic [DATA_W-1:0]   go_data,
   input  logic [DATA_W/8-1:0] go_strb,
   output logic                cmp_valid,
   output logic                cmp_err,
   output logic [DATA_W-1:0]   cmp_data,
   output logic [ADDR_W-1:0]   m_awaddr,
   output logic                m_awvalid,
   input  logic                m_awready,
   output logic [DATA_W-1:0]   m_wdata,
   output logic [DATA_W/8-1:0] m_wstrb,
   output logic                m_wvalid,
   input  logic                m_wready,
   input  logic [1:0]          m_bresp,
   input  logic                m_bvalid,
   output logic                m_bready,
   output logic [ADDR_W-1:0]   m_araddr,
   output logic                m_arvalid,
   input  logic                m_arready,
   input  logic [DATA_W-1:0]   m_rdata,
   input  logic [1:0]          m_rresp,
   input  logic                m_rvalid,
   output logic                m_rready
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_awvalid <= 1'b0;
         m_wvalid  <= 1'b0;
         m_bready  <= 1'b0;
         m_arvalid <= 1'b0;
         m_rready  <= 1'b0;
         m_awaddr  <= '0;
         m_araddr  <= '0;
         m_wdata   <= '0;
         m_wstrb   <= '0;
         cmp_valid <= 1'b0;
         cmp_err   <= 1'b0;
         cmp_data  <= '0;
      end else begin
         cmp_valid <= 1'b0;
         if (go && !go_read) begin
            m_awvalid <= 1'b1;
            m_wvalid  <= 1'b1;
            m_bready  <= 1'b1;
            m_awaddr  <= go_addr;
            m_wdata   <= go_data;
            m_wstrb   <= go_strb;
         end
         if (go && go_read) begin
            m_arvalid <= 1'b1;
            m_rready  <= 1'b1;
            m_araddr  <= go_addr;
         end
         if (m_awvalid && m_awready) m_awvalid <= 1'b0;
         if (m_wvalid && m_wready)   m_wvalid  <= 1'b0;
         if (m_arvalid && m_arready) m_arvalid <= 1'b0;
         if (m_bready && m_bvalid) begin
            m_bready  <= 1'b0;
            cmp_valid <= 1'b1;
            cmp_err   <= (m_bresp != RESP_OKAY);
         end
         if (m_rready && m_rvalid) begin
            m_rready  <= 1'b0;
            cmp_valid <= 1'b1;
            cmp_err   <= (m_rresp != RESP_OKAY);
            cmp_data  <= m_rdata;
         end
      end
   end

   AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr))); // R5
   AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wstrb))); // R5
   AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr))); // R5
   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid || m_wvalid || m_bready) |-> !(m_arvalid || m_rready)); // R6

endmodule

// File: rtl/axil_tg_check.sv
module axil_tg_check #(
   parameter int DATA_W = 32,
   parameter int ERR_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmp_valid,
   input  logic                cmp_read,
   input  logic                cmp_err,
   input  logic [DATA_W-1:0]   rd_data,
   input  logic [DATA_W-1:0]   exp_data,
   input  logic [DATA_W/8-1:0] exp_strb,
   output logic [ERR_W-1:0]    err_count,
   output logic                fail
);
   localparam int STRB_W = DATA_W / 8;

   logic [STRB_W-1:0] lane_bad;
   logic              hit;

   for (genvar b = 0; b < STRB_W; b++) begin : g_cmp
      assign lane_bad[b] = exp_strb[b] && (rd_data[8*b +: 8] != exp_data[8*b +: 8]);
   end

   assign hit = cmp_valid && (cmp_err || (cmp_read && (|lane_bad)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_count <= '0;
         fail      <= 1'b0;
      end else if (hit) begin
         fail <= 1'b1;
         if (err_count != '1) err_count <= err_count + 1'b1;
      end
   end

   AST_ERR_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      err_count >= $past(err_count)); // R9
   AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count - $past(err_count)) <= ERR_W'(1)); // R9
   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fail) |-> fail); // R9
   AST_FAIL_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      fail == (err_count != '0)); // R9

endmodule

// File: rtl/axil_traffic_gen.sv
module axil_traffic_gen
   import axil_tg_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                DATA_W    = 32,
   parameter int                NUM_PAIRS = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
   parameter int unsigned       STRIDE    = 16,
   parameter int                ERR_W     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   output logic [ADDR_W-1:0]   m_awaddr,
   output logic [2:0]          m_awprot,
   output logic                m_awvalid,
   input  logic                m_awready,
   output logic [DATA_W-1:0]   m_wdata,
   output logic [DATA_W/8-1:0] m_wstrb,
   output logic                m_wvalid,
   input  logic                m_wready,
   input  logic [1:0]          m_bresp,
   input  logic                m_bvalid,
   output logic                m_bready,
   output logic [ADDR_W-1:0]   m_araddr,
   output logic [2:0]          m_arprot,
   output logic                m_arvalid,
   input  logic                m_arready,
   input  logic [DATA_W-1:0]   m_rdata,
   input  logic [1:0]          m_rresp,
   input  logic                m_rvalid,
   output logic                m_rready,
   output logic                done,
   output logic                pass,
   output logic                fail,
   output logic [ERR_W-1:0]    err_count
);
   localparam int             NUM_TX = 2 * NUM_PAIRS;
   localparam int             IDX_W  = (NUM_TX > 2) ? $clog2(NUM_TX) : 1;
   localparam int             STRB_W = DATA_W / 8;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_TX - 1);

   if (DATA_W < 32 || DATA_W % 32 != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of 32");
   end
   if (NUM_PAIRS < 1) begin : g_bad_pairs
      $error("NUM_PAIRS must be at least 1");
   end
   if (STRIDE < STRB_W) begin : g_bad_stride
      $error("STRIDE must cover one data word");
   end
   if (ERR_W < 1) begin : g_bad_err
      $error("ERR_W must be at least 1");
   end

   seq_state_e        state;
   logic [IDX_W-1:0]  idx;
   logic              ent_read;
   logic [ADDR_W-1:0] ent_addr;
   logic [DATA_W-1:0] ent_data;
   logic [STRB_W-1:0] ent_strb;
   logic              cmp_valid;
   logic              cmp_err;
   logic [DATA_W-1:0] cmp_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         idx   <= '0;
      end else begin
         case (state)
            SEQ_IDLE:   if (start) state <= SEQ_LAUNCH;
            SEQ_LAUNCH: state <= SEQ_WAIT;
            SEQ_WAIT: if (cmp_valid) begin
               if (idx == LAST) state <= SEQ_DONE;
               else begin
                  idx   <= idx + 1'b1;
                  state <= SEQ_LAUNCH;
               end
            end
            default:    state <= SEQ_DONE;
         endcase
      end
   end

   axil_tg_table #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
      .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE)
   ) table_i (
      .idx(idx), .is_read(ent_read), .addr(ent_addr),
      .data(ent_data), .strb(ent_strb)
   );

   axil_tg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_i (
      .clk(clk), .rst_n(rst_n),
      .go(state == SEQ_LAUNCH), .go_read(ent_read), .go_addr(ent_addr),
      .go_data(ent_data), .go_strb(ent_strb),
      .cmp_valid(cmp_valid), .cmp_err(cmp_err), .cmp_data(cmp_data),
      .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
      .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
      .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
      .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
      .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
   );

   axil_tg_check #(.DATA_W(DATA_W), .ERR_W(ERR_W)) check_i (
      .clk(clk), .rst_n(rst_n),
      .cmp_valid(cmp_valid), .cmp_read(ent_read), .cmp_err(cmp_err),
      .rd_data(cmp_data), .exp_data(ent_data), .exp_strb(ent_strb),
      .err_count(err_count), .fail(fail)
   );

   assign m_awprot = 3'b000;
   assign m_arprot = 3'b000;
   assign done     = (state == SEQ_DONE);
   assign pass     = done && !fail;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE) |-> !(m_awvalid || m_wvalid || m_arvalid)); // R2
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done) |-> done); // R10
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(m_awvalid || m_wvalid || m_arvalid || m_bready || m_rready)); // R10

endmodule

// File: tb/axil_traffic_gen_tb_top.sv
`timescale 1ns/1ps
module axil_traffic_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] m_awaddr, m_araddr, m_wdata, m_rdata;
   logic [2:0]  m_awprot, m_arprot;
   logic [3:0]  m_wstrb;
   logic        m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
   logic        m_arvalid, m_arready, m_rvalid, m_rready;
   logic [1:0]  m_bresp, m_rresp;
   logic        done, pass, fail;
   logic [7:0]  err_count;

   always #10 clk = ~clk;

   axil_traffic_gen dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(m_awready),
      .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
      .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
      .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arvalid(m_arvalid), .m_arready(m_arready),
      .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
      .done(done), .pass(pass), .fail(fail), .err_count(err_count)
   );

   // {is_read, addr, data, strb} per transaction, R3/R4
   localparam logic [68:0] VEC [16] = '{
      {1'b0, 32'h00, 32'h0123_4567, 4'hF}, {1'b1, 32'h00, 32'h0123_4567, 4'hF},
      {1'b0, 32'h10, 32'h89AB_CDEF, 4'hF}, {1'b1, 32'h10, 32'h89AB_CDEF, 4'hF},
      {1'b0, 32'h20, 32'h8787_8787, 4'hF}, {1'b1, 32'h20, 32'h8787_8787, 4'hF},
      {1'b0, 32'h30, 32'h9696_9696, 4'h5}, {1'b1, 32'h30, 32'h9696_9696, 4'h5},
      {1'b0, 32'h40, 32'hE1E1_E1E1, 4'hF}, {1'b1, 32'h40, 32'hE1E1_E1E1, 4'hF},
      {1'b0, 32'h50, 32'hF0F0_F0F0, 4'hF}, {1'b1, 32'h50, 32'hF0F0_F0F0, 4'hF},
      {1'b0, 32'h60, 32'hC3C3_C3C3, 4'hF}, {1'b1, 32'h60, 32'hC3C3_C3C3, 4'hF},
      {1'b0, 32'h70, 32'hD2D2_D2D2, 4'h5}, {1'b1, 32'h70, 32'hD2D2_D2D2, 4'h5}
   };

   // injection controls, driven only by the stimulus block
   int          inj_b = -1;
   int          inj_r = -1;
   logic [31:0] inj_xor [16];

   // slave model state, driven only by the slave block
   logic [31:0] mem [16];
   int          cyc, tx_i, vec_chk, vec_bad;
   logic        aw_got, w_got, ar_got, b_fire, r_fire, overlap, prot_bad;
   logic [31:0] aw_a, w_d, ar_a;
   logic [3:0]  w_s;

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] = 32'hDEAD_BEEF;
         cyc = 0; tx_i = 0;
         aw_got = 0; w_got = 0; ar_got = 0; b_fire = 0; r_fire = 0;
         overlap = 0; prot_bad = 0;
         m_awready = 0; m_wready = 0; m_arready = 0;
         m_bvalid = 0; m_rvalid = 0; m_bresp = 0; m_rresp = 0; m_rdata = 0;
      end else begin
         cyc++;
         if (b_fire) m_bvalid = 0;
         if (r_fire) m_rvalid = 0;
         // responses for handshakes completed at earlier edges
         if (aw_got && w_got && !m_bvalid) begin
            vec_chk++;
            if (tx_i > 15 || VEC[tx_i] != {1'b0, aw_a, w_d, w_s}) begin
               vec_bad++;
               $display("FAIL R3/R4 write tx %0d: got %h expected %h", tx_i,
                        {1'b0, aw_a, w_d, w_s}, (tx_i > 15) ? 69'h0 : VEC[tx_i]);
            end
            if (int'(aw_a[7:4]) == inj_b) m_bresp = 2'b10;
            else begin
               m_bresp = 2'b00;
               for (int b = 0; b < 4; b++)
                  if (w_s[b]) mem[aw_a[7:4]][8*b +: 8] = w_d[8*b +: 8];
            end
            m_bvalid = 1; aw_got = 0; w_got = 0; tx_i++;
         end
         if (ar_got && !m_rvalid) begin
            vec_chk++;
            if (tx_i > 15 || VEC[tx_i][68] != 1'b1 || VEC[tx_i][67:36] != ar_a) begin
               vec_bad++;
               $display("FAIL R3 read tx %0d: got addr %h expected %h", tx_i, ar_a,
                        (tx_i > 15) ? 32'h0 : VEC[tx_i][67:36]);
            end
            m_rdata  = mem[ar_a[7:4]] ^ inj_xor[ar_a[7:4]];
            m_rresp  = (int'(ar_a[7:4]) == inj_r) ? 2'b10 : 2'b00;
            m_rvalid = 1; ar_got = 0; tx_i++;
         end
         m_awready = (cyc % 3) != 1;
         m_wready  = (cyc % 4) != 2;
         m_arready = (cyc % 2) == 0;
         if ((m_awvalid || m_wvalid) && m_arvalid) overlap = 1;
         if (m_awvalid && m_awready && !aw_got) begin
            aw_got = 1; aw_a = m_awaddr;
            if (m_awprot != 3'b000) prot_bad = 1;
         end
         if (m_wvalid && m_wready && !w_got) begin
            w_got = 1; w_d = m_wdata; w_s = m_wstrb;
         end
         if (m_arvalid && m_arready && !ar_got) begin
            ar_got = 1; ar_a = m_araddr;
            if (m_arprot != 3'b000) prot_bad = 1;
         end
         b_fire = m_bvalid && m_bready;
         r_fire = m_rvalid && m_rready;
      end
   end

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0; start = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk + vec_chk, n_bad + vec_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) inj_xor[i] = 32'h0;
      // R1: reset state
      do_reset();
      @(negedge clk);
      check({m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready, done, pass, fail} == 8'h0
            && err_count == 0, "R1 reset outputs",
            {m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready, done, pass, fail, err_count}, 0);
      // R2: stays idle without start
      repeat (40) @(negedge clk);
      check(!m_awvalid && !m_arvalid && !m_wvalid && tx_i == 0 && !done, "R2 idle before start",
            {m_awvalid, m_wvalid, m_arvalid, done}, 0);
      // R2: a one-cycle pulse is enough
      start = 1; @(negedge clk); start = 0;
      wait_done();
      check(done, "R10 done after clean run", done, 1);
      check(tx_i == 16, "R3 transaction count", tx_i, 16);
      check(err_count == 0, "R8 clean run error count", err_count, 0);
      check(pass && !fail, "R10 pass on clean run", {pass, fail}, 2'b10);
      check(!overlap, "R6 one transaction in flight", overlap, 0);
      check(!prot_bad, "R5 protection bits zero", prot_bad, 0);
      // R10: no traffic after done, status held
      repeat (30) @(negedge clk);
      check(tx_i == 16 && !m_awvalid && !m_arvalid && done && pass, "R10 quiet and held after done",
            {tx_i[7:0], done, pass}, {8'd16, 2'b11});

      // R8: enabled-lane corruption counts, unenabled lanes ignored
      inj_xor[2] = 32'h0001_0000;
      inj_xor[3] = 32'h0000_FF00;
      inj_xor[7] = 32'hFF00_0000;
      do_reset();
      start = 1;
      wait_done();
      check(err_count == 1, "R8 only enabled-lane mismatch counts", err_count, 1);
      check(fail && !pass, "R9 fail sticky after mismatch", {fail, pass}, 2'b10);
      repeat (10) @(negedge clk);
      check(fail && err_count == 1, "R9 status held", {fail, err_count}, {1'b1, 8'd1});

      // R7/R8: write and read response errors
      for (int i = 0; i < 16; i++) inj_xor[i] = 32'h0;
      inj_b = 5;
      inj_r = 0;
      do_reset();
      @(negedge clk);
      check(err_count == 0 && !fail, "R1 reset clears errors", {fail, err_count}, 0);
      start = 1;
      wait_done();
      check(err_count == 3, "R7 R8 response errors and lost write", err_count, 3);
      check(done && fail && !pass, "R10 verdict after errors", {done, fail, pass}, 3'b110);
      start = 0;
      finish_run();
   end

endmodule